// File: doc/BRIEF.md
# Debounced Pin-Group Change Capture

This block watches a group of eight external input pins that may change at any time. It brings them into the internal clock domain through two back-to-back register stages. Software can read both stages. A programmable stability window then filters the resynchronised value. A new pin pattern is accepted only once it has held unchanged for the whole window. On acceptance the pattern is stored in a capture register and a sticky interrupt is raised.

Software programs the window length through a small synchronous register bus. It reads the captured pattern and clears the interrupt by writing a one to a status bit. A window of zero turns filtering off, so nothing is captured and no interrupt is raised. A window of one is unsupported and is reported by a status flag.

The bus uses these offsets:
- 0x28: first stage, read only
- 0x2C: second stage, read only
- 0x30: window length, read/write
- 0x34: captured pattern, read only
- 0x38: status, with bit 0 the pending interrupt (write one to clear) and bit 1 the unsupported-window flag

Top module: `pin_persist_filter`

## Requirements
- R1: After reset the first stage, second stage, window, capture and status registers read zero, `irq_o` is low and `rdata_o` is zero.
- R2: Offset 0x28 returns the pins as sampled by the previous clock edge, and offset 0x2C returns the value that 0x28 held one edge earlier. Each value is in bits [7:0], and bits [31:8] read zero.
- R3: Offset 0x30 holds the 8-bit window PT. A write stores wdata[7:0], and bits [31:8] read back as zero.
- R4: With PT of 2 or more, a pattern that differs from the captured value and is held at the pins for PT+1 or more sampling edges is accepted. Taking the first edge that samples it as edge 1, the capture register and `irq_o` update at edge PT+3.
- R5: With PT of 2 or more, a pattern held at the pins for PT or fewer sampling edges is not captured and raises no interrupt.
- R6: A stable pattern equal to the captured value raises no interrupt and does not change the capture register.
- R7: With PT equal to 0, the capture register never changes and `irq_o` never rises.
- R8: `irq_o` stays high until software writes 0x38 with bit 0 set. Writing 0x38 with bit 0 clear has no effect. Status bit 0 reads back the pending interrupt.
- R9: When an acceptance and a clear write happen on the same edge, the interrupt stays set.
- R10: A read presents data on `rdata_o` the cycle after `rd_en_i`. `rdata_o` keeps its value while no read is requested. Unmapped offsets read zero.
- R11: Status bit 1 reads 1 exactly when PT equals 1.
- R12: Writes to the read-only offsets 0x28, 0x2C and 0x34 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | External input pins, asynchronous |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Sticky interrupt, level high |

## Verification
An acceptance and a software write-one-to-clear on the status register can land on the same clock edge. To provoke this, the bench leaves an earlier interrupt pending and drives a new pattern. It counts edges to the exact acceptance edge predicted by R4 and issues the clear write so that it is sampled on that same edge. The bench then expects `irq_o` to remain high and the new pattern to be readable from the capture register. A plain clear issued afterwards must drop the interrupt.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
  localparam int unsigned PPF_AW = 8;
  localparam int unsigned PPF_DW = 32;

  localparam logic [PPF_AW-1:0] OFF_STAGE1 = 8'h28;
  localparam logic [PPF_AW-1:0] OFF_STAGE2 = 8'h2C;
  localparam logic [PPF_AW-1:0] OFF_WINDOW = 8'h30;
  localparam logic [PPF_AW-1:0] OFF_CAPTURE = 8'h34;
  localparam logic [PPF_AW-1:0] OFF_STATUS = 8'h38;

  localparam int unsigned STAT_PEND_BIT = 0;
  localparam int unsigned STAT_BADPT_BIT = 1;
endpackage

// File: rtl/ppf_sync2.sv
module ppf_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] s1_o,
  output logic [W-1:0] s2_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign s1_o = s1_q;
  assign s2_o = s2_q;
endmodule

// File: rtl/ppf_filter.sv
module ppf_filter #(
  parameter int unsigned W    = 8,
  parameter int unsigned PT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    s2_i,
  input  logic [PT_W-1:0] pt_i,
  output logic [W-1:0]    cap_o,
  output logic            fire_o
);
  localparam logic [PT_W-1:0] CNT_MAX = '1;

  logic [W-1:0]    prev_q, cap_q;
  logic [PT_W-1:0] cnt_q;
  logic            same, enough, fire;

  // cnt_q = k while s2 is equal to prev means s2 has held for k+2 cycles
  assign same   = (s2_i == prev_q);
  assign enough = (cnt_q >= (pt_i - PT_W'(1)));
  assign fire   = (pt_i != '0) && same && enough && (s2_i != cap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= s2_i;
      if (!same)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + PT_W'(1);
      if (fire) cap_q <= s2_i;
    end
  end

  assign cap_o  = cap_q;
  assign fire_o = fire;
endmodule

// File: rtl/ppf_regs.sv
module ppf_regs
  import ppf_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned PT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PPF_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [PPF_DW-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [PPF_DW-1:0] rdata_o,
  input  logic [W-1:0]      s1_i,
  input  logic [W-1:0]      s2_i,
  input  logic [W-1:0]      cap_i,
  input  logic              fire_i,
  output logic [PT_W-1:0]   pt_o,
  output logic              irq_o
);
  logic [PT_W-1:0]   pt_q;
  logic              irq_q;
  logic [PPF_DW-1:0] rdata_q, rd_mux;
  logic              clr;

  assign clr = wr_en_i && (addr_i == OFF_STATUS) && wdata_i[STAT_PEND_BIT];

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFF_STAGE1:  rd_mux[W-1:0] = s1_i;
      OFF_STAGE2:  rd_mux[W-1:0] = s2_i;
      OFF_WINDOW:  rd_mux[PT_W-1:0] = pt_q;
      OFF_CAPTURE: rd_mux[W-1:0] = cap_i;
      OFF_STATUS: begin
        rd_mux[STAT_PEND_BIT]  = irq_q;
        rd_mux[STAT_BADPT_BIT] = (pt_q == PT_W'(1));
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pt_q    <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_en_i && addr_i == OFF_WINDOW) pt_q <= wdata_i[PT_W-1:0];
      if (fire_i)   irq_q <= 1'b1;  // set beats clear
      else if (clr) irq_q <= 1'b0;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign pt_o    = pt_q;
  assign irq_o   = irq_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/pin_persist_filter.sv
module pin_persist_filter
  import ppf_pkg::*;
#(
  parameter int unsigned PIN_W = 8,
  parameter int unsigned PT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic [PPF_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [PPF_DW-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [PPF_DW-1:0] rdata_o,
  output logic              irq_o
);
  logic [PIN_W-1:0] s1, s2, cap;
  logic [PT_W-1:0]  pt;
  logic             fire;

  ppf_sync2 #(.W(PIN_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .s1_o  (s1),
    .s2_o  (s2)
  );

  ppf_filter #(.W(PIN_W), .PT_W(PT_W)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .s2_i  (s2),
    .pt_i  (pt),
    .cap_o (cap),
    .fire_o(fire)
  );

  ppf_regs #(.W(PIN_W), .PT_W(PT_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .rd_en_i(rd_en_i),
    .rdata_o(rdata_o),
    .s1_i   (s1),
    .s2_i   (s2),
    .cap_i  (cap),
    .fire_i (fire),
    .pt_o   (pt),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/ppf_checker.sv
module ppf_checker
  import ppf_pkg::*;
#(
  parameter int unsigned PIN_W = 8,
  parameter int unsigned PT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PIN_W-1:0]  s1_i,
  input logic [PIN_W-1:0]  s2_i,
  input logic [PIN_W-1:0]  cap_i,
  input logic [PT_W-1:0]   pt_i,
  input logic              fire_i,
  input logic              irq_i,
  input logic [PPF_AW-1:0] addr_i,
  input logic              wr_en_i,
  input logic [PPF_DW-1:0] wdata_i,
  input logic              rd_en_i,
  input logic [PPF_DW-1:0] rdata_i
);
  a_r2_stage_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_i == $past(s1_i));

  a_r4_rise_with_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> cap_i != $past(cap_i));

  a_r6_same_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_i == cap_i && !irq_i) |=> !irq_i);

  a_r7_off_cap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_i == '0) |=> $stable(cap_i));

  a_r7_off_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_i == '0 && !irq_i) |=> !irq_i);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_STATUS && wdata_i[STAT_PEND_BIT] && !fire_i) |=> !irq_i);

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> irq_i);

  a_r10_read_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_WINDOW) |=> rdata_i == PPF_DW'($past(pt_i)));

  a_r10_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_i));
endmodule

bind pin_persist_filter ppf_checker #(.PIN_W(PIN_W), .PT_W(PT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .s1_i   (s1),
  .s2_i   (s2),
  .cap_i  (cap),
  .pt_i   (pt),
  .fire_i (fire),
  .irq_i  (irq_o),
  .addr_i (addr_i),
  .wr_en_i(wr_en_i),
  .wdata_i(wdata_i),
  .rd_en_i(rd_en_i),
  .rdata_i(rdata_o)
);

// File: tb/pin_persist_filter_test.sv
module pin_persist_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pin_persist_filter uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pins_i (pins),
    .addr_i (addr),
    .wr_en_i(wr_en),
    .wdata_i(wdata),
    .rd_en_i(rd_en),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic exp_accept(input int len, input int pt,
                                      input logic [7:0] v, input logic [7:0] cur);
    return (pt >= 2) && (v != cur) && (len >= pt + 1);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  cur, v;
    int          pt, len;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    bus_rd(8'h28, d); check("R1 stage1", d, 32'h0);
    bus_rd(8'h2C, d); check("R1 stage2", d, 32'h0);
    bus_rd(8'h30, d); check("R1 window", d, 32'h0);
    bus_rd(8'h34, d); check("R1 capture", d, 32'h0);
    bus_rd(8'h38, d); check("R1 status", d, 32'h0);

    // R2 stage pipeline, PT still 0
    @(negedge clk); pins = 8'h96; addr = 8'h2C; rd_en = 1'b1;
    @(negedge clk); check("R2 stage2 old", rdata, 32'h0);
    pins = 8'h69; addr = 8'h28;
    @(negedge clk); check("R2 stage1 lag", rdata, 32'h96);
    addr = 8'h2C;
    @(negedge clk); check("R2 stage2 lag", rdata, 32'h96);
    addr = 8'h28;
    @(negedge clk); check("R2 stage1 new", rdata, 32'h69);
    rd_en = 1'b0;

    // R7 PT=0: long stable new value must not capture
    repeat (30) @(negedge clk);
    check("R7 irq", {31'b0, irq}, 32'h0);
    bus_rd(8'h34, d); check("R7 capture", d, 32'h0);

    pins = 8'h00;
    repeat (6) @(negedge clk);

    // R3 / R11
    bus_wr(8'h30, 32'hFFFF_FF01);
    bus_rd(8'h38, d); check("R11 bad window flag", d, 32'h2);
    bus_wr(8'h30, 32'hFFFF_FF04);
    bus_rd(8'h30, d); check("R3 window readback", d, 32'h4);
    bus_rd(8'h38, d); check("R11 flag clear", d, 32'h0);

    // R6 stable equal to capture
    repeat (20) @(negedge clk);
    check("R6 no irq", {31'b0, irq}, 32'h0);

    // R4 exact latency, PT=4
    @(negedge clk); pins = 8'h3C;
    repeat (4 + 2) @(negedge clk);
    check("R4 not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R4 irq at edge PT+3", {31'b0, irq}, 32'h1);
    bus_rd(8'h34, d); check("R4 capture", d, 32'h3C);

    // R9 clear on acceptance edge; irq already pending
    @(negedge clk); pins = 8'h5A;
    repeat (4 + 2) @(negedge clk);
    addr = 8'h38; wdata = 32'h1; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R9 set wins", {31'b0, irq}, 32'h1);
    bus_rd(8'h34, d); check("R9 capture", d, 32'h5A);

    // R8 sticky and W1C
    bus_wr(8'h38, 32'h0);
    check("R8 zero write no effect", {31'b0, irq}, 32'h1);
    bus_rd(8'h38, d); check("R8 pending bit", d, 32'h1);
    bus_wr(8'h38, 32'h1);
    check("R8 cleared", {31'b0, irq}, 32'h0);
    bus_rd(8'h38, d); check("R8 status cleared", d, 32'h0);

    // R4/R5/R6 random pulses
    cur = 8'h5A;
    for (int it = 0; it < 24; it++) begin
      pt = 2 + int'($urandom % 11);
      bus_wr(8'h30, 32'(pt));
      v = (it % 4 == 0) ? cur : 8'($urandom);
      len = 1 + int'($urandom % (pt + 5));
      if (it == 1) len = pt;
      if (it == 2) len = pt + 1;
      if (it == 1 || it == 2) v = cur ^ 8'hFF;
      @(negedge clk); pins = v;
      repeat (len) @(negedge clk);
      pins = cur;
      repeat (pt + 10) @(negedge clk);
      check(exp_accept(len, pt, v, cur) ? "R4 random accept" : "R5/R6 random reject",
            {31'b0, irq}, {31'b0, exp_accept(len, pt, v, cur)});
      bus_rd(8'h34, d); check("R5 capture settles", d, 32'(cur));
      bus_wr(8'h38, 32'h1);
    end

    // R7 PT=0 again with a different value
    bus_wr(8'h30, 32'h0);
    pins = 8'hA5;
    repeat (30) @(negedge clk);
    check("R7 irq off", {31'b0, irq}, 32'h0);
    bus_rd(8'h34, d); check("R7 capture held", d, 32'h5A);

    // R12 read-only writes
    bus_wr(8'h34, 32'hFF);
    bus_wr(8'h28, 32'h11);
    bus_wr(8'h2C, 32'h22);
    bus_rd(8'h34, d); check("R12 capture untouched", d, 32'h5A);
    bus_rd(8'h28, d); check("R12 stage1 untouched", d, 32'hA5);
    bus_rd(8'h2C, d); check("R12 stage2 untouched", d, 32'hA5);

    // R10 unmapped and hold
    bus_rd(8'h30, d);
    bus_rd(8'h40, d); check("R10 unmapped zero", d, 32'h0);
    bus_rd(8'h2C, d);
    repeat (4) @(negedge clk);
    check("R10 hold", rdata, 32'hA5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule